// File: doc/BRIEF.md
# Dual Byte Buffer Serial Access Port

This block holds two independent 264-byte scratch buffers and lets a host on a four-wire serial link (serial clock, active-low select, serial data in, serial data out) fill them and read them back. Each transaction opens with an 8-bit command byte. The command picks the buffer and the direction. After some padding bits, a 9-bit start address follows. The block then either takes whole bytes from the data-in line into consecutive buffer locations, or sends consecutive buffer bytes out on the data-out line. The address steps once per byte, and after location 263 it goes back to location 0. Raising the select line ends the transaction at once.

All serial inputs are sampled by the system clock `clk`. The serial clock is edge-detected, so each serial clock level must be held for at least two `clk` cycles. Data-in is taken on rising serial clock edges. Data-out is updated after falling edges, so the host can sample it on the next rising edge. All bytes travel most significant bit first. Writes use a 32-bit header and reads use a 40-bit header. A command byte outside the defined set makes the block sit out the rest of the transaction.

Top module: `sbuf_dual`

## Requirements
- R1: Command byte 0x84 writes buffer A and 0x87 writes buffer B. The header is the command byte, then 15 ignored bits, then the 9-bit start address. Data bytes follow directly, and each complete byte is stored at the current address.
- R2: Command bytes 0x54 or 0xD4 read buffer A, and 0x56 or 0xD6 read buffer B. The header is the command byte, 15 ignored bits, the 9-bit address and 8 more ignored bits. The first data bit is on `so` with `so_en` high before the first rising edge after the header, and each later bit follows a falling edge.
- R3: The two buffers are independent: writing one never changes the contents of the other.
- R4: The byte address advances by one after every byte, for writes and for reads alike, and goes from 263 to 0.
- R5: A start address of 264 or above is taken as address 0.
- R6: A byte cut short by `cs_n` rising (fewer than 8 bits received) is dropped, and the location it would have filled keeps its old value.
- R7: For any other command byte, the rest of the transaction is ignored: no buffer changes and `so_en` stays low.
- R8: `so_en` is high only in the data phase of a read. It is low after reset, during every header and write, and from the third `clk` cycle after `cs_n` goes high. While `so_en` is low, `so` is 0.
- R9: `cs_n` rising at any point, whether inside a header or inside a data byte, aborts the command. The next select-low period starts a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low transaction select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host (0 when not enabled) |
| so_en | output | 1 | Output enable for `so`; high only while read data is driven |

## Verification
The hardest case to reach from the ports is the boundary where the two kinds of edge interact. This happens in a read that must hold its first bit across the falling edge that ends the header, and in a write cut off by select after only a few bits of a byte. The stimulus drives the serial clock bit by bit from a task. This lets it stop a command at an arbitrary bit count: inside the header, after three bits of a data byte, or in the middle of a read byte. Both buffers are first filled completely, so every later read-back of the locations near 263 and 0 is compared against known data. That covers the wrap, the out-of-range start and the dropped partial byte.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  localparam int NUM_BUFS  = 2;
  localparam int OPC_BITS  = 8;
  localparam int SKIP_BITS = 15;
  localparam int TAIL_BITS = 8;

  localparam logic [7:0] OPC_WR_A     = 8'h84;
  localparam logic [7:0] OPC_WR_B     = 8'h87;
  localparam logic [7:0] OPC_RD_A     = 8'h54;
  localparam logic [7:0] OPC_RD_A_ALT = 8'hD4;
  localparam logic [7:0] OPC_RD_B     = 8'h56;
  localparam logic [7:0] OPC_RD_B_ALT = 8'hD6;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_HDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_e;

  typedef struct packed {
    logic       shiftEn;
    logic       wrEn;
    logic       bufSel;
    logic [2:0] bitIdx;
  } strobe_t;

endpackage

// File: rtl/sbuf_bank.sv
module sbuf_bank #(
  parameter int DEPTH  = 264,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int BUF_BYTES = 264,
  parameter int ADDR_W    = $clog2(BUF_BYTES),
  parameter int RX_W      = (ADDR_W > 8) ? ADDR_W : 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              si,
  input  logic [RX_W-1:0]   rxWord,
  output logic              siBit,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] addr,
  output phase_e            phase
);

  localparam int OPC_LAST  = OPC_BITS - 1;
  localparam int ADDR_LAST = OPC_BITS + SKIP_BITS + ADDR_W - 1;
  localparam int TAIL_LAST = ADDR_LAST + TAIL_BITS;
  localparam int CNT_W     = $clog2(TAIL_LAST + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BUF_BYTES - 1);

  logic              sckQ, sckPrev, csQ, siQ;
  phase_e            phaseQ;
  logic [CNT_W-1:0]  hdrCnt;
  logic [2:0]        bitCnt;
  logic [ADDR_W-1:0] addrQ;
  logic              bufQ, isRead, outTaken;

  logic              rise, fall;
  phase_e            decPhase;
  logic              decRead, decBuf;
  logic [ADDR_W-1:0] nextAddr, startAddr, rxAddr;

  assign rise = sckQ & ~sckPrev;
  assign fall = ~sckQ & sckPrev;

  // command byte decode
  always_comb begin
    decPhase = PH_SKIP;
    decRead  = 1'b0;
    decBuf   = 1'b0;
    case (rxWord[7:0])
      OPC_WR_A: decPhase = PH_HDR;
      OPC_WR_B: begin
        decPhase = PH_HDR;
        decBuf   = 1'b1;
      end
      OPC_RD_A, OPC_RD_A_ALT: begin
        decPhase = PH_HDR;
        decRead  = 1'b1;
      end
      OPC_RD_B, OPC_RD_B_ALT: begin
        decPhase = PH_HDR;
        decRead  = 1'b1;
        decBuf   = 1'b1;
      end
      default: ;
    endcase
  end

  assign rxAddr    = rxWord[ADDR_W-1:0];
  assign startAddr = (32'(rxAddr) >= BUF_BYTES) ? '0 : rxAddr;
  assign nextAddr  = (addrQ == LAST_ADDR) ? '0 : addrQ + ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ     <= 1'b0;
      sckPrev  <= 1'b0;
      csQ      <= 1'b1;
      siQ      <= 1'b0;
      phaseQ   <= PH_OPC;
      hdrCnt   <= '0;
      bitCnt   <= '0;
      addrQ    <= '0;
      bufQ     <= 1'b0;
      isRead   <= 1'b0;
      outTaken <= 1'b0;
    end else begin
      sckQ    <= sck;
      sckPrev <= sckQ;
      csQ     <= csN;
      siQ     <= si;
      if (csQ) begin
        phaseQ   <= PH_OPC;
        hdrCnt   <= '0;
        bitCnt   <= '0;
        outTaken <= 1'b0;
      end else if (rise) begin
        case (phaseQ)
          PH_OPC: begin
            hdrCnt <= hdrCnt + CNT_W'(1);
            if (hdrCnt == CNT_W'(OPC_LAST)) begin
              phaseQ <= decPhase;
              isRead <= decRead;
              bufQ   <= decBuf;
            end
          end
          PH_HDR: begin
            hdrCnt <= hdrCnt + CNT_W'(1);
            if (hdrCnt == CNT_W'(ADDR_LAST)) begin
              addrQ <= startAddr;
              if (!isRead) begin
                phaseQ <= PH_WDATA;
                bitCnt <= '0;
              end
            end
            if (isRead && hdrCnt == CNT_W'(TAIL_LAST)) begin
              phaseQ   <= PH_RDATA;
              bitCnt   <= '0;
              outTaken <= 1'b0;
            end
          end
          PH_WDATA: begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) addrQ <= nextAddr;
          end
          PH_RDATA: outTaken <= 1'b1;
          default: ;
        endcase
      end else if (fall && phaseQ == PH_RDATA && outTaken) begin
        // host has sampled the current bit: present the next one
        outTaken <= 1'b0;
        bitCnt   <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) addrQ <= nextAddr;
      end
    end
  end

  assign stb.shiftEn = rise & ~csQ;
  assign stb.wrEn    = rise & ~csQ & (phaseQ == PH_WDATA) & (bitCnt == 3'd7);
  assign stb.bufSel  = bufQ;
  assign stb.bitIdx  = bitCnt;

  assign siBit = siQ;
  assign addr  = addrQ;
  assign phase = phaseQ;

endmodule

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
#(
  parameter int BUF_BYTES = 264,
  parameter int ADDR_W    = $clog2(BUF_BYTES),
  parameter int RX_W      = (ADDR_W > 8) ? ADDR_W : 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              siBit,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  output logic [RX_W-1:0]   rxWord,
  output logic              soBit
);

  logic [RX_W-2:0] shiftReg;
  logic [7:0]      rdData [NUM_BUFS];
  logic [7:0]      soByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= rxWord[RX_W-2:0];
  end

  assign rxWord = {shiftReg, siBit};

  for (genvar g = 0; g < NUM_BUFS; g++) begin : gBank
    logic bankWe;
    assign bankWe = stb.wrEn && (stb.bufSel == 1'(g));
    sbuf_bank #(
      .DEPTH (BUF_BYTES),
      .ADDR_W(ADDR_W)
    ) u_bank (
      .clk  (clk),
      .we   (bankWe),
      .addr (addr),
      .wdata(rxWord[7:0]),
      .rdata(rdData[g])
    );
  end

  assign soByte = rdData[stb.bufSel];
  assign soBit  = soByte[3'd7 - stb.bitIdx];

endmodule

// File: rtl/sbuf_dual.sv
module sbuf_dual
  import sbuf_pkg::*;
#(
  parameter int BUF_BYTES = 264
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_en
);

  localparam int ADDR_W = $clog2(BUF_BYTES);
  localparam int RX_W   = (ADDR_W > 8) ? ADDR_W : 8;

  strobe_t           ctl;
  phase_e            phase;
  logic [ADDR_W-1:0] addr;
  logic [RX_W-1:0]   rxWord;
  logic              siBit, dpSo;

  sbuf_ctrl #(
    .BUF_BYTES(BUF_BYTES),
    .ADDR_W   (ADDR_W),
    .RX_W     (RX_W)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rst_n),
    .sck   (sck),
    .csN   (cs_n),
    .si    (si),
    .rxWord(rxWord),
    .siBit (siBit),
    .stb   (ctl),
    .addr  (addr),
    .phase (phase)
  );

  sbuf_datapath #(
    .BUF_BYTES(BUF_BYTES),
    .ADDR_W   (ADDR_W),
    .RX_W     (RX_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rst_n),
    .siBit (siBit),
    .stb   (ctl),
    .addr  (addr),
    .rxWord(rxWord),
    .soBit (dpSo)
  );

  assign so_en = (phase == PH_RDATA);
  assign so    = so_en & dpSo;

endmodule

// File: rtl/sbuf_dual_chk.sv
module sbuf_dual_chk
  import sbuf_pkg::*;
#(
  parameter int BUF_BYTES = 264,
  parameter int ADDR_W    = $clog2(BUF_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              soEn,
  input logic              wrEn,
  input phase_e            phase,
  input logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BUF_BYTES - 1);

  // R8: select held high for two samples drops the output enable
  assert_oe_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |=> !soEn);

  // R8: stores never happen while data is being driven out
  assert_wr_noe_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !soEn);

  // R4: address always inside the buffer
  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    32'(addr) < BUF_BYTES);

  // R4: a store advances the address by one with wrap at the end
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((($past(addr) == LAST_ADDR) && (addr == '0)) ||
              (($past(addr) != LAST_ADDR) && (addr == $past(addr) + ADDR_W'(1)))));

  // R7: an unknown command neither stores nor drives
  assert_skip_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SKIP) |-> (!wrEn && !soEn));

endmodule

bind sbuf_dual sbuf_dual_chk #(
  .BUF_BYTES(BUF_BYTES),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk  (clk),
  .rstN (rst_n),
  .csN  (cs_n),
  .soEn (so_en),
  .wrEn (ctl.wrEn),
  .phase(phase),
  .addr (addr)
);

// File: tb/sbuf_dual_bench.sv
module sbuf_dual_bench;

  localparam int BYTES = 264;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic so, so_en;

  always #5 clk = ~clk;

  sbuf_dual u_sbuf_dual (
    .clk  (clk),
    .rst_n(rst_n),
    .sck  (sck),
    .cs_n (cs_n),
    .si   (si),
    .so   (so),
    .so_en(so_en)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] refMem [2][BYTES];
  logic [7:0] expQ [$];
  logic [7:0] rxQ [$];
  string      tagQ [$];
  logic lastSo, lastOe, oeSeen;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int clampA(input int a);
    return (a >= BYTES) ? 0 : a;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 37 + i * 11 + 3);
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk);
    si = b;
    repeat (HALF) @(negedge clk);
    lastSo = so;
    lastOe = so_en;
    oeSeen = oeSeen | so_en;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic header(input logic [7:0] opc, input int start, input bit withTail);
    logic [8:0] a;
    a = 9'(start);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    oeSeen = 1'b0;
    sendByte(opc);
    repeat (15) sendBit(1'b0);
    for (int i = 8; i >= 0; i--) sendBit(a[i]);
    if (withTail) repeat (8) sendBit(1'b0);
  endtask

  task automatic endCmd();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic writeSeq(input int bufi, input int start, input int n, input int seed);
    int a;
    logic [7:0] v;
    header(bufi ? 8'h87 : 8'h84, start, 1'b0);
    a = clampA(start);
    for (int i = 0; i < n; i++) begin
      v = pat(seed, i);
      sendByte(v);
      refMem[bufi][a] = v;
      a = (a + 1) % BYTES;
    end
    check(oeSeen == 1'b0, "R8", "so_en during write", int'(oeSeen), 0);
    endCmd();
  endtask

  task automatic readSeq(input int bufi, input int start, input int n,
                         input bit alt, input string tag);
    int a;
    logic [7:0] opc, v;
    if (bufi == 0) opc = alt ? 8'hD4 : 8'h54;
    else           opc = alt ? 8'hD6 : 8'h56;
    header(opc, start, 1'b1);
    check(oeSeen == 1'b0, "R8", "so_en during read header", int'(oeSeen), 0);
    a = clampA(start);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(refMem[bufi][a]);
      tagQ.push_back(tag);
      a = (a + 1) % BYTES;
      for (int b = 7; b >= 0; b--) begin
        sendBit(1'b0);
        v[b] = lastSo;
        if (i == 0 && b == 7)
          check(lastOe == 1'b1, "R2", "so_en at first data bit", int'(lastOe), 1);
      end
      rxQ.push_back(v);
    end
    endCmd();
    check(so_en == 1'b0, "R8", "so_en after select high", int'(so_en), 0);
  endtask

  // scoreboard monitor
  logic [7:0] mRx, mExp;
  string mTag;
  initial begin
    forever begin
      wait (rxQ.size() != 0);
      mRx = rxQ.pop_front();
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected read byte", int'(mRx), 0);
      end else begin
        mExp = expQ.pop_front();
        mTag = tagQ.pop_front();
        check(mRx == mExp, mTag, "read byte", int'(mRx), int'(mExp));
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(so_en == 1'b0, "R8", "so_en after reset", int'(so_en), 0);
    check(so == 1'b0, "R8", "so after reset", int'(so), 0);

    // fill both buffers completely (R1 full-length write with wrap-free run)
    writeSeq(0, 0, BYTES, 9);
    writeSeq(1, 0, BYTES, 11);

    // R1: basic write and read of buffer A
    writeSeq(0, 5, 6, 1);
    readSeq(0, 5, 6, 1'b0, "R1");

    // R3 / R2: buffer B with alternate read opcodes, buffer A untouched
    writeSeq(1, 5, 6, 2);
    readSeq(1, 5, 6, 1'b1, "R3");
    readSeq(0, 5, 6, 1'b1, "R3");

    // R4: write and read across the 263 -> 0 boundary
    writeSeq(0, 261, 5, 3);
    readSeq(0, 261, 5, 1'b0, "R4");
    readSeq(1, 262, 4, 1'b0, "R4");

    // R5: start address above the buffer is taken as 0
    writeSeq(1, 300, 2, 4);
    readSeq(1, 0, 3, 1'b0, "R5");
    readSeq(1, 400, 2, 1'b1, "R5");

    // R6: partial trailing byte is dropped
    header(8'h84, 20, 1'b0);
    sendByte(8'hA5);
    refMem[0][20] = 8'hA5;
    repeat (3) sendBit(1'b1);
    endCmd();
    readSeq(0, 20, 2, 1'b0, "R6");

    // R7: unknown command ignored
    header(8'h3C, 20, 1'b0);
    sendByte(8'h00);
    sendByte(8'hFF);
    check(oeSeen == 1'b0, "R7", "so_en during unknown command", int'(oeSeen), 0);
    endCmd();
    readSeq(0, 20, 2, 1'b0, "R7");
    readSeq(0, 0, 2, 1'b0, "R7");

    // R9: abort inside a header, then a fresh command works
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    sendByte(8'h87);
    repeat (10) sendBit(1'b1);
    endCmd();
    writeSeq(1, 40, 3, 7);
    readSeq(1, 40, 3, 1'b0, "R9");

    // R9: abort inside a read byte, then read again
    header(8'h56, 40, 1'b1);
    repeat (4) sendBit(1'b0);
    endCmd();
    check(so_en == 1'b0, "R9", "so_en after aborted read", int'(so_en), 0);
    readSeq(1, 41, 2, 1'b1, "R9");

    repeat (20) @(negedge clk);
    wait (rxQ.size() == 0);
    check(expQ.size() == 0, "R2", "pending expected bytes", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule